// File: doc/BRIEF.md
# Predicated Vector Arithmetic Right Shifter with Lane-Shared Counts

This unit is a SIMD datapath stage. It shifts each element of a source vector right arithmetically, so the sign is kept. The shift counts come from a second vector that is divided into 64-bit lanes. Every element takes its count from the 64-bit lane that contains its lowest bit. When elements are narrower than 64 bits, all the elements inside one lane therefore share a single count.

The full 64-bit count is read as an unsigned number. It is clamped to the element width and is never wrapped, so a large count fills the element with copies of its sign bit.

A per-byte predicate decides which elements are active. An inactive element passes its source value through unchanged. The element width comes from a two-bit size code. One size code is reserved: for that code the unit flags an illegal request and produces no result.

The operation is captured on a valid strobe. The result and its valid appear one clock later. The vector length is a parameter and must be a multiple of 64 bits.

Top module: `vshr_wide_top`

## Requirements
- R1: The size code selects the element width: 2'b00 selects 8 bits, 2'b01 selects 16 bits and 2'b10 selects 32 bits. Element e occupies bits [e*w +: w].
- R2: A request with size code 2'b11 raises `out_illegal` for one cycle, one clock after capture. In that cycle `out_valid` stays low, and `out_res` keeps its previous value.
- R3: Element e takes its count from bits [64*((e*w)/64) +: 64] of `in_cnt`.
- R4: The count is treated as an unsigned 64-bit value. Any set bit above bit 5 makes the effective shift equal to the element width.
- R5: The effective shift is min(count, w). A shift of w or more gives all-zeros for a non-negative element and all-ones for a negative element.
- R6: Element e is active when predicate bit (e*w)/8 is set. The other predicate bits that fall inside the element have no effect.
- R7: An inactive element's result equals its source element, unchanged.
- R8: When no element is active, `out_res` equals `in_src`.
- R9: `out_valid` rises exactly one clock after a legal request is captured and lasts one cycle. Reset (`rst_n` low, synchronous) clears `out_valid`, `out_illegal` and `out_res`.
- R10: While `in_valid` is low, the inputs are ignored and `out_res` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture strobe |
| in_size | input | 2 | Element size code |
| in_src | input | VL | Source vector to shift |
| in_cnt | input | VL | Shift-count vector, 64-bit lanes |
| in_pred | input | VL/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Reserved size code was requested |
| out_res | output | VL | Merged result vector |

## Verification
Two things meet in the same cycle of every element: the clamping of the count and the predicate merge. A narrow element can be inactive while its lane carries a count large enough to saturate. The merge must win in that case, and the clamp must never leak into the inactive bytes.

The bench provokes this case in two ways. It uses random predicates together with counts that have high bits set or sit exactly at the width. It also uses directed patterns where the only set predicate bits fall on non-lowest bytes of elements.

Each result is judged against a bench model that computes the element result and the merge separately. The comparison covers the whole vector.

// File: rtl/vshr_pkg.sv
// Shared types and helpers for the wide-count vector shifter.
// Assumes a 64-bit count lane and element widths of at most 32 bits.
package vshr_pkg;

    localparam int LANE_W = 64;
    localparam int AMT_W  = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } vshr_size_e;

    // Clamp an unsigned 64-bit count to the element width.
    function automatic logic [AMT_W-1:0] clamp_amt(input logic [LANE_W-1:0] cnt,
                                                   input int unsigned       ew);
        logic [AMT_W-1:0] ew_v;
        ew_v = AMT_W'(ew);
        if ((|cnt[LANE_W-1:AMT_W]) || (cnt[AMT_W-1:0] >= ew_v))
            return ew_v;
        return cnt[AMT_W-1:0];
    endfunction

endpackage

// File: rtl/vshr_elem.sv
// One element slice: arithmetic right shift by a pre-clamped amount, or
// pass-through of the source when the element is inactive.
// Assumes amt never exceeds EW.
module vshr_elem #(
    parameter int EW = 8
) (
    input  logic [EW-1:0]           opnd,
    input  logic [vshr_pkg::AMT_W-1:0] amt,
    input  logic                    act,
    output logic [EW-1:0]           res
);
    logic [EW-1:0] shifted;

    // Sign-preserving shift; an amount of EW yields pure sign fill.
    always_comb shifted = EW'($signed(opnd) >>> amt);

    // Merge: inactive element keeps its source value.
    always_comb res = act ? shifted : opnd;
endmodule

// File: rtl/vshr_lane.sv
// One 64-bit lane: builds the byte, half and word variants side by side
// from the lane's shared count and selects one by size code.
// Assumes the reserved size code is filtered at the top; it passes opnd.
module vshr_lane
    import vshr_pkg::*;
#(
    parameter int LW = LANE_W,
    localparam int PB = LW / 8
) (
    input  logic [LW-1:0] opnd,
    input  logic [LW-1:0] cnt,
    input  logic [PB-1:0] pred,
    input  logic [1:0]    size,
    output logic [LW-1:0] res
);
    logic [LW-1:0] part [3];

    for (genvar gi = 0; gi < 3; gi++) begin : g_sz
        localparam int EW = 8 << gi;
        localparam int NE = LW / EW;
        logic [AMT_W-1:0] amt;

        // Clamp the shared lane count for this element width.
        always_comb amt = clamp_amt(cnt, EW);

        for (genvar j = 0; j < NE; j++) begin : g_el
            vshr_elem #(.EW(EW)) u_elem (
                .opnd (opnd[j*EW +: EW]),
                .amt  (amt),
                .act  (pred[(j*EW)/8]),
                .res  (part[gi][j*EW +: EW])
            );
        end
    end

    // Pick the variant that matches the requested element width.
    always_comb begin
        unique case (vshr_size_e'(size))
            SZ_BYTE: res = part[0];
            SZ_HALF: res = part[1];
            SZ_WORD: res = part[2];
            default: res = opnd;
        endcase
    end
endmodule

// File: rtl/vshr_pred_scan.sv
// Reports whether any element is active. Only the predicate bit at each
// element's lowest byte counts, so the mask depends on the size code.
module vshr_pred_scan #(
    parameter int PW = 32
) (
    input  logic [PW-1:0] pred,
    input  logic [1:0]    size,
    output logic          any_act
);
    logic [PW-1:0] sel;

    // Build the mask of element-leading predicate bits for this size.
    always_comb begin
        for (int b = 0; b < PW; b++) begin
            unique case (size)
                2'b00:   sel[b] = 1'b1;
                2'b01:   sel[b] = (b % 2) == 0;
                2'b10:   sel[b] = (b % 4) == 0;
                default: sel[b] = 1'b0;
            endcase
        end
    end

    // Reduce the masked predicate.
    always_comb any_act = |(pred & sel);
endmodule

// File: rtl/vshr_wide_top.sv
// Predicated arithmetic right shifter with 64-bit lane-shared counts.
// One register stage; a reserved size code raises out_illegal and leaves
// the result register untouched. VL must be a multiple of 64.
module vshr_wide_top
    import vshr_pkg::*;
#(
    parameter int VL = 256,
    localparam int PW    = VL / 8,
    localparam int LANES = VL / LANE_W,
    localparam int PPL   = LANE_W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_size,
    input  logic [VL-1:0] in_src,
    input  logic [VL-1:0] in_cnt,
    input  logic [PW-1:0] in_pred,
    output logic          out_valid,
    output logic          out_illegal,
    output logic [VL-1:0] out_res
);
    logic          any_act;
    logic          legal;
    logic [VL-1:0] cnt_eff;
    logic [VL-1:0] comb_res;

    vshr_pred_scan #(.PW(PW)) u_scan (
        .pred    (in_pred),
        .size    (in_size),
        .any_act (any_act)
    );

    // Size decode: only the reserved code is illegal.
    always_comb legal = (vshr_size_e'(in_size) != SZ_RSVD);

    // With no active element the count vector is forced to zero.
    always_comb cnt_eff = any_act ? in_cnt : '0;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vshr_lane #(.LW(LANE_W)) u_lane (
            .opnd (in_src[l*LANE_W +: LANE_W]),
            .cnt  (cnt_eff[l*LANE_W +: LANE_W]),
            .pred (in_pred[l*PPL +: PPL]),
            .size (in_size),
            .res  (comb_res[l*LANE_W +: LANE_W])
        );
    end

    // Output stage: capture on valid, flag reserved codes, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_res     <= '0;
        end else begin
            out_valid   <= in_valid && legal;
            out_illegal <= in_valid && !legal;
            if (in_valid && legal)
                out_res <= comb_res;
        end
    end
endmodule

// File: rtl/vshr_wide_chk.sv
// Protocol checker for vshr_wide_top, attached by bind.
module vshr_wide_chk #(
    parameter int VL = 256,
    localparam int PW = VL / 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    in_size,
    input logic [VL-1:0] in_src,
    input logic [PW-1:0] in_pred,
    input logic          out_valid,
    input logic          out_illegal,
    input logic [VL-1:0] out_res
);
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size != 2'b11) |=> (out_valid && !out_illegal)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal)); // R9
    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'b11) |=> (out_illegal && !out_valid)); // R2
    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'b11) |=> $stable(out_res)); // R2
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_illegal)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_res)); // R10
    AST_NONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size != 2'b11 && in_pred == '0) |=> (out_res == $past(in_src))); // R8
endmodule

bind vshr_wide_top vshr_wide_chk #(.VL(VL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_size     (in_size),
    .in_src      (in_src),
    .in_pred     (in_pred),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_res     (out_res)
);

// File: tb/test_vshr_wide_top.sv
module test_vshr_wide_top;
    localparam int VL = 256;
    localparam int PW = VL / 8;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_size = 2'b00;
    logic [VL-1:0] in_src = '0;
    logic [VL-1:0] in_cnt = '0;
    logic [PW-1:0] in_pred = '0;
    logic          out_valid;
    logic          out_illegal;
    logic [VL-1:0] out_res;

    int n_run = 0;
    int n_fail = 0;
    logic [VL-1:0] last_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vshr_wide_top #(.VL(VL)) i_vshr_wide_top (
        .clk, .rst_n, .in_valid, .in_size, .in_src, .in_cnt, .in_pred,
        .out_valid, .out_illegal, .out_res
    );

    // Behavioural model of the whole vector operation.
    function automatic logic [VL-1:0] model(input logic [1:0] sz, input logic [VL-1:0] src,
                                            input logic [VL-1:0] cnt, input logic [PW-1:0] pr);
        logic [VL-1:0] r;
        int es;
        r = src;
        es = 8 << sz;
        for (int e = 0; e < VL / es; e++) begin
            if (pr[(e*es)/8]) begin
                logic [63:0] c;
                logic [31:0] x;
                longint v, m;
                int sh;
                c = cnt[((e*es)/64)*64 +: 64];
                x = 32'(src >> (e*es));
                m = (longint'(1) << es) - 1;
                v = longint'(x) & m;
                if (v[es-1]) v = v - (longint'(1) << es);
                sh = (c >= 64'(es)) ? es : int'(c);
                v = v >>> sh;
                for (int b = 0; b < es; b++) r[e*es + b] = v[b];
            end
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [63:0] rnd_cnt(input int es);
        int k;
        k = $urandom_range(0, 5);
        case (k)
            0: return 64'd0;
            1: return 64'(es - 1);
            2: return 64'(es);
            3: return {$urandom, $urandom} | 64'h0000_0001_0000_0000;
            default: return 64'($urandom_range(0, 40));
        endcase
    endfunction

    task automatic check(input string req, input logic ok, input logic [VL-1:0] act,
                         input logic [VL-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request and check result one clock later.
    task automatic run(input string req, input logic [1:0] sz, input logic [VL-1:0] src,
                       input logic [VL-1:0] cnt, input logic [PW-1:0] pr);
        logic [VL-1:0] exp;
        @(negedge clk);
        in_valid = 1'b1; in_size = sz; in_src = src; in_cnt = cnt; in_pred = pr;
        @(negedge clk);
        in_valid = 1'b0;
        if (sz == 2'b11) begin
            check({req, " R2 flag"}, out_illegal === 1'b1 && out_valid === 1'b0,
                  VL'({out_illegal, out_valid}), VL'(2'b10));
            check({req, " R2 hold"}, out_res === last_res, out_res, last_res);
        end else begin
            exp = model(sz, src, cnt, pr);
            check({req, " R9 valid"}, out_valid === 1'b1 && out_illegal === 1'b0,
                  VL'({out_illegal, out_valid}), VL'(2'b01));
            check(req, out_res === exp, out_res, exp);
            last_res = exp;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++; n_run++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [VL-1:0] c;
        logic [VL-1:0] s;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset", out_valid === 1'b0 && out_illegal === 1'b0 && out_res === '0,
              out_res, '0);
        rst_n = 1'b1;

        s = {8{32'h8421_7F80}};
        for (int sz = 0; sz < 3; sz++) begin
            int es;
            es = 8 << sz;
            // R1/R5: counts 0, es-1, es in every lane
            run("R1 cnt0", 2'(sz), s, '0, '1);
            run("R5 cnt es-1", 2'(sz), s, {4{64'(es - 1)}}, '1);
            run("R5 cnt es", 2'(sz), s, {4{64'(es)}}, '1);
            // R4: high bits above bit 31 set, low bits small
            run("R4 high bits", 2'(sz), s, {4{64'h8000_0000_0000_0001}}, '1);
            run("R4 bit32", 2'(sz), s, {4{64'h0000_0001_0000_0000}}, '1);
            // R3: distinct count per lane
            run("R3 lane counts", 2'(sz), s, {64'd1, 64'd2, 64'd3, 64'd4}, '1);
            // R6: only non-leading predicate bits set
            run("R6 nonlead pred", 2'(sz), s, {4{64'd3}}, {PW/2{2'b10}});
            // R7: alternating active bytes
            run("R7 merge", 2'(sz), s, {4{64'd70}}, {PW/4{4'b0011}});
            // R8: no active element
            run("R8 none active", 2'(sz), s, {4{64'd5}}, '0);
        end

        // R2: reserved size after a known result
        run("R2 reserved", 2'b11, rnd_vec(), rnd_vec(), '1);

        // R10: idle with changing inputs
        @(negedge clk);
        in_valid = 1'b0; in_size = 2'b00; in_src = rnd_vec(); in_cnt = '0; in_pred = '1;
        @(negedge clk);
        check("R10 idle hold", out_res === last_res && out_valid === 1'b0, out_res, last_res);

        // Random mix of sizes, counts and predicates
        for (int it = 0; it < 400; it++) begin
            logic [1:0] sz;
            int es;
            sz = 2'($urandom_range(0, 3));
            es = (sz == 2'b11) ? 8 : (8 << sz);
            for (int l = 0; l < VL / 64; l++) c[l*64 +: 64] = rnd_cnt(es);
            run("R1 R3 R5 R6 R7 random", sz, rnd_vec(), c, PW'(rnd_vec()));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule